// File: doc/BRIEF.md
# Fractional Clock Divider with Triangular Spread

This block derives a slower clock from a fast input clock by a 16.16 fixed-point divide ratio. No single integer divisor gives that ratio. Each output period therefore counts one of the two integers that bracket the ratio. A fractional accumulator decides which one, so the divisor averaged over many periods equals the programmed ratio exactly. The output is high for the first half of each period and low for the rest, which keeps the duty cycle close to 50%.

A triangular modulation can be laid over the ratio to spread the output spectrum.
- In down-spread, the ratio only ever grows, so the frequency only ever drops.
- In center-spread, the nominal ratio is first lowered by half the depth, which raises the frequency. The same one-sided ramp is then applied on top.

The ramp moves one step per output period. Its step size and its turnaround length come from a depth value and a power-of-two rate value. A disable input removes the modulation without touching the spread settings. A start-up phase offset delays the first output edge, but only when no modulation is active.

Top module: `frac_spread_div`

## Requirements
- R1: While `rst_i` is high, `clk_o` is low. The accumulator, the ramp and the phase delay all return to zero.
- R2: `ratio_i[31:16]` is the integer part of the ratio and `ratio_i[15:0]` is the fraction. At the start of each period, the fraction of the effective ratio is added to a 16-bit accumulator that starts at zero. A carry out of that sum selects integer part + 1 as the divisor, and no carry selects the integer part.
- R3: A period of D input cycles drives `clk_o` high for D - floor(D/2) cycles and then low for floor(D/2) cycles. The high phase comes first.
- R4: An effective ratio below 2.0 is treated as exactly 2.0. An effective ratio above the 32-bit maximum saturates at that maximum.
- R5: Spread is active when `spread_en_i`=1 and `spread_dis_i`=0. While it is active, a ramp offset is added to the ratio. The offset starts at 0 and changes only at period starts, by step = `spread_depth_i` >> `spread_rate_i`. It rises for 2^`spread_rate_i` periods, falls for the same number, and then repeats. The period that starts a step uses the offset value from before that step.
- R6: With `spread_center_i`=1 (center mode) and spread active, the effective ratio is `ratio_i` - (`spread_depth_i` >> 1) + offset. With `spread_center_i`=0 (down mode), it is `ratio_i` + offset.
- R7: When spread is not active, the effective ratio equals `ratio_i`. The ramp is held at zero, so it restarts from zero when spread becomes active again.
- R8: Out of reset with spread inactive, the first rising edge of `clk_o` comes `phase_i` input cycles later than with `phase_i`=0. With spread active, `phase_i` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock |
| rst_i | input | 1 | Synchronous active-high divider reset |
| ratio_i | input | 32 | Divide ratio, 16 integer and 16 fractional bits |
| spread_en_i | input | 1 | Enable triangular modulation |
| spread_center_i | input | 1 | 1 = center mode, 0 = down mode |
| spread_dis_i | input | 1 | Forces the unmodulated ratio |
| spread_depth_i | input | 16 | Peak ratio excursion in fractional units |
| spread_rate_i | input | 4 | log2 of periods per ramp half |
| phase_i | input | 8 | Start-up delay of the first edge in input cycles |
| clk_o | output | 1 | Divided clock |

## Verification
The bench targets the following corner cases. A fraction of one quarter must place exactly one long period in every four. An accumulator that skipped the carry, or took it one period late, would shift or lose the long period. Ratios at and below 2.0 check the clamp: without it the divisor would fall to one or zero and the output would stall or glitch. Odd divisors check that the extra cycle lands in the high phase. Down and center ramps check the period-by-period divisor sequence, so a wrong step, a wrong turnaround count or a missing half-depth shift changes a specific period length. With the disable input set, or with spread on while a phase offset is requested, the bench checks that the outputs ignore the settings that are meant to have no effect.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;

    localparam int INT_W   = 16;
    localparam int FRAC_W  = 16;
    localparam int RATIO_W = INT_W + FRAC_W;
    localparam int OFF_W   = 16;
    localparam int RATE_W  = 4;
    localparam int PHASE_W = 8;
    localparam int CNT_W   = INT_W + 1;

    typedef enum logic {
        SPREAD_DOWN   = 1'b0,
        SPREAD_CENTER = 1'b1
    } spread_kind_e;

    typedef struct packed {
        logic [INT_W-1:0]  whole;
        logic [FRAC_W-1:0] frac;
    } ratio_t;

    typedef enum logic {
        RAMP_UP   = 1'b0,
        RAMP_DOWN = 1'b1
    } ramp_dir_e;

    localparam ratio_t MIN_RATIO = '{whole: INT_W'(2), frac: '0};
    localparam ratio_t MAX_RATIO = '{whole: '1, frac: '1};

    function automatic logic [CNT_W-1:0] low_part(input logic [CNT_W-1:0] d);
        return d >> 1;
    endfunction

endpackage

// File: rtl/fdiv_spread_gen.sv
module fdiv_spread_gen
    import fdiv_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              active_i,
    input  logic              adv_i,
    input  logic [OFF_W-1:0]  depth_i,
    input  logic [RATE_W-1:0] rate_i,
    output logic [OFF_W-1:0]  offset_o
);
    localparam int TURN_W = 1 << RATE_W;

    ramp_dir_e          dir_q;
    logic [TURN_W-1:0]  pos_q;
    logic [OFF_W-1:0]   off_q;
    logic [OFF_W-1:0]   step;
    logic [TURN_W-1:0]  last_pos;

    always_comb begin
        step     = depth_i >> rate_i;
        last_pos = TURN_W'((33'd1 << rate_i) - 33'd1);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i || !active_i) begin
            dir_q <= RAMP_UP;
            pos_q <= '0;
            off_q <= '0;
        end else if (adv_i) begin
            if (dir_q == RAMP_UP) begin
                off_q <= off_q + step;
            end else begin
                off_q <= off_q - step;
            end
            if (pos_q == last_pos) begin
                pos_q <= '0;
                dir_q <= (dir_q == RAMP_UP) ? RAMP_DOWN : RAMP_UP;
            end else begin
                pos_q <= pos_q + 1'b1;
            end
        end
    end

    assign offset_o = off_q;

endmodule

// File: rtl/fdiv_ratio_sel.sv
module fdiv_ratio_sel
    import fdiv_pkg::*;
(
    input  logic [RATIO_W-1:0] ratio_i,
    input  logic               active_i,
    input  spread_kind_e       kind_i,
    input  logic [OFF_W-1:0]   depth_i,
    input  logic [OFF_W-1:0]   offset_i,
    output ratio_t             eff_o
);
    localparam int WIDE_W = RATIO_W + 2;

    logic [WIDE_W-1:0] wide;

    always_comb begin
        wide = {2'b00, ratio_i};
        if (active_i) begin
            wide = wide + WIDE_W'(offset_i);
            if (kind_i == SPREAD_CENTER) begin
                wide = wide - WIDE_W'(depth_i >> 1);
            end
        end
        if (wide[WIDE_W-1]) begin
            eff_o = MIN_RATIO;
        end else if (wide[WIDE_W-2]) begin
            eff_o = MAX_RATIO;
        end else if (wide[RATIO_W-1:0] < MIN_RATIO) begin
            eff_o = MIN_RATIO;
        end else begin
            eff_o = ratio_t'(wide[RATIO_W-1:0]);
        end
    end

endmodule

// File: rtl/fdiv_period_gen.sv
module fdiv_period_gen
    import fdiv_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_i,
    input  ratio_t             eff_i,
    input  logic               skip_phase_i,
    input  logic [PHASE_W-1:0] phase_i,
    output logic               load_o,
    output logic [CNT_W-1:0]   div_o,
    output logic               clk_o
);
    logic                started_q;
    logic [PHASE_W-1:0]  dly_q;
    logic [CNT_W-1:0]    cnt_q;
    logic [CNT_W-1:0]    low_q;
    logic [FRAC_W-1:0]   acc_q;
    logic                clk_q;
    logic [FRAC_W:0]     sum;

    always_comb begin
        sum    = {1'b0, acc_q} + {1'b0, eff_i.frac};
        div_o  = {1'b0, eff_i.whole} + CNT_W'(sum[FRAC_W]);
        if (started_q) begin
            load_o = (cnt_q == '0);
        end else begin
            load_o = skip_phase_i || (dly_q >= phase_i);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            started_q <= 1'b0;
            dly_q     <= '0;
            cnt_q     <= '0;
            low_q     <= '0;
            acc_q     <= '0;
            clk_q     <= 1'b0;
        end else if (load_o) begin
            started_q <= 1'b1;
            cnt_q     <= div_o - CNT_W'(1);
            low_q     <= low_part(div_o);
            acc_q     <= sum[FRAC_W-1:0];
            clk_q     <= 1'b1;
        end else if (!started_q) begin
            dly_q <= dly_q + 1'b1;
        end else begin
            cnt_q <= cnt_q - CNT_W'(1);
            if (cnt_q == low_q) begin
                clk_q <= 1'b0;
            end
        end
    end

    assign clk_o = clk_q;

endmodule

// File: rtl/frac_spread_div.sv
module frac_spread_div
    import fdiv_pkg::*;
(
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic [31:0]         ratio_i,
    input  logic                spread_en_i,
    input  logic                spread_center_i,
    input  logic                spread_dis_i,
    input  logic [15:0]         spread_depth_i,
    input  logic [3:0]          spread_rate_i,
    input  logic [7:0]          phase_i,
    output logic                clk_o
);
    logic             spread_act;
    logic             period_load;
    logic [CNT_W-1:0] div_sel;
    logic [OFF_W-1:0] spread_off;
    ratio_t           eff_ratio;
    spread_kind_e     kind;

    assign spread_act = spread_en_i && !spread_dis_i;
    assign kind       = spread_kind_e'(spread_center_i);

    fdiv_spread_gen u_ramp (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .active_i (spread_act),
        .adv_i    (period_load),
        .depth_i  (spread_depth_i),
        .rate_i   (spread_rate_i),
        .offset_o (spread_off)
    );

    fdiv_ratio_sel u_sel (
        .ratio_i  (ratio_i),
        .active_i (spread_act),
        .kind_i   (kind),
        .depth_i  (spread_depth_i),
        .offset_i (spread_off),
        .eff_o    (eff_ratio)
    );

    fdiv_period_gen u_per (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .eff_i        (eff_ratio),
        .skip_phase_i (spread_act),
        .phase_i      (phase_i),
        .load_o       (period_load),
        .div_o        (div_sel),
        .clk_o        (clk_o)
    );

endmodule

// File: rtl/fdiv_checker.sv
module fdiv_checker (
    input logic        clk_i,
    input logic        rst_i,
    input logic        clk_o,
    input logic        period_load,
    input logic [16:0] div_sel,
    input logic [31:0] eff_ratio,
    input logic [15:0] spread_off,
    input logic [15:0] spread_depth_i,
    input logic        spread_act
);
    AST_RESET_LOW: assert property (@(posedge clk_i) rst_i |=> !clk_o); // R1

    AST_DIV_NEIGHBOR: assert property (@(posedge clk_i) disable iff (rst_i)
        period_load |-> (div_sel == {1'b0, eff_ratio[31:16]}) ||
                        (div_sel == {1'b0, eff_ratio[31:16]} + 17'd1)); // R2

    AST_LOAD_RISES: assert property (@(posedge clk_i) disable iff (rst_i)
        period_load |=> clk_o); // R3

    AST_DIV_FLOOR: assert property (@(posedge clk_i) disable iff (rst_i)
        period_load |-> div_sel >= 17'd2); // R4

    AST_RAMP_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        (spread_act && !period_load) |=> $stable(spread_off)); // R5

    AST_RAMP_BOUND: assert property (@(posedge clk_i) disable iff (rst_i)
        spread_off <= spread_depth_i); // R5

    AST_IDLE_FLAT: assert property (@(posedge clk_i) disable iff (rst_i)
        !spread_act |=> spread_off == 16'd0); // R7
endmodule

bind frac_spread_div fdiv_checker u_chk (
    .clk_i          (clk_i),
    .rst_i          (rst_i),
    .clk_o          (clk_o),
    .period_load    (period_load),
    .div_sel        (div_sel),
    .eff_ratio      (eff_ratio),
    .spread_off     (spread_off),
    .spread_depth_i (spread_depth_i),
    .spread_act     (spread_act)
);

// File: tb/test_frac_spread_div.sv
module test_frac_spread_div;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] ratio = 32'h0004_0000;
    logic        sp_en = 1'b0;
    logic        sp_ctr = 1'b0;
    logic        sp_dis = 1'b0;
    logic [15:0] sp_depth = 16'h0;
    logic [3:0]  sp_rate = 4'h0;
    logic [7:0]  phase = 8'h0;
    logic        clk_out;

    always #2.5 clk = ~clk;

    frac_spread_div i_frac_spread_div (
        .clk_i           (clk),
        .rst_i           (rst),
        .ratio_i         (ratio),
        .spread_en_i     (sp_en),
        .spread_center_i (sp_ctr),
        .spread_dis_i    (sp_dis),
        .spread_depth_i  (sp_depth),
        .spread_rate_i   (sp_rate),
        .phase_i         (phase),
        .clk_o           (clk_out)
    );

    typedef struct {
        int    hi;
        int    lo;
        string tag;
    } exp_t;

    exp_t  exp_q[$];
    int    checks = 0;
    int    errors = 0;
    int    popped = 0;
    int    exp_first = 0;
    string first_tag = "";

    // monitor state
    int hi_cnt, lo_cnt, since;
    bit seen, first_done;

    always @(negedge clk) begin
        if (rst) begin
            hi_cnt = 0; lo_cnt = 0; since = 0; seen = 0; first_done = 0;
        end else begin
            since++;
            if (clk_out) begin
                if (!first_done) begin
                    first_done = 1;
                    checks++;
                    if (since != exp_first) begin
                        errors++;
                        $display("FAIL %s first edge latency: actual %0d expected %0d",
                                 first_tag, since, exp_first);
                    end
                end
                if (seen && lo_cnt > 0) begin
                    if (exp_q.size() > 0) begin
                        exp_t e;
                        e = exp_q.pop_front();
                        popped++;
                        checks++;
                        if (hi_cnt != e.hi || lo_cnt != e.lo) begin
                            errors++;
                            $display("FAIL %s period %0d: actual hi=%0d lo=%0d expected hi=%0d lo=%0d",
                                     e.tag, popped, hi_cnt, lo_cnt, e.hi, e.lo);
                        end
                    end
                    hi_cnt = 0;
                    lo_cnt = 0;
                end
                seen = 1;
                hi_cnt++;
            end else if (seen) begin
                lo_cnt++;
            end
        end
    end

    // Driver: reference model from the requirements, pushes expected periods
    task automatic run_case(input logic [31:0] r, input bit en, input bit ctr,
                            input bit dis, input logic [15:0] depth,
                            input logic [3:0] rate, input logic [7:0] ph,
                            input int n, input string tag);
        longint acc = 0, off = 0, e, sum, d;
        int     pos = 0;
        bit     down = 0;
        bit     act;
        longint step, last;
        @(posedge clk); #1;
        rst = 1'b1;
        ratio = r; sp_en = en; sp_ctr = ctr; sp_dis = dis;
        sp_depth = depth; sp_rate = rate; phase = ph;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++; // R1: output low in reset
        if (clk_out !== 1'b0) begin
            errors++;
            $display("FAIL R1 clk_o in reset: actual %b expected 0", clk_out);
        end
        exp_q.delete();
        popped = 0;
        act  = en && !dis;
        step = longint'(depth) >> rate;
        last = (longint'(1) << rate) - 1;
        exp_first = act ? 2 : int'(ph) + 2; // R8
        first_tag = act ? {tag, " R8 phase ignored"} : {tag, " R8 phase delay"};
        for (int k = 0; k < n; k++) begin
            exp_t x;
            e = longint'(r);
            if (act) begin
                e = e + off;
                if (ctr) e = e - (longint'(depth) >> 1);
            end
            if (e < 64'h2_0000) e = 64'h2_0000;
            if (e > 64'hFFFF_FFFF) e = 64'hFFFF_FFFF;
            sum = acc + (e & 64'hFFFF);
            d   = (e >> 16) + (sum >> 16);
            acc = sum & 64'hFFFF;
            x.hi = int'(d - d / 2);
            x.lo = int'(d / 2);
            x.tag = tag;
            exp_q.push_back(x);
            if (act) begin
                off = down ? off - step : off + step;
                if (pos == last) begin
                    pos = 0;
                    down = !down;
                end else begin
                    pos++;
                end
            end
        end
        @(posedge clk); #1;
        rst = 1'b0;
        while (popped < n) @(negedge clk);
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R2 R3: integer even ratio
        run_case(32'h0004_0000, 0, 0, 0, 16'h0, 4'd0, 8'd0, 6, "R2/R3 ratio 4.0");
        // R3: odd divisor puts extra cycle high
        run_case(32'h0005_0000, 0, 0, 0, 16'h0, 4'd0, 8'd0, 6, "R3 ratio 5.0");
        // R2: quarter fraction, one long period in four
        run_case(32'h0004_4000, 0, 0, 0, 16'h0, 4'd0, 8'd0, 12, "R2 ratio 4.25");
        // R2: near-one fraction
        run_case(32'h0006_F000, 0, 0, 0, 16'h0, 4'd0, 8'd0, 20, "R2 ratio 6.9375");
        // R4: minimum and below-minimum
        run_case(32'h0002_8000, 0, 0, 0, 16'h0, 4'd0, 8'd0, 8, "R4 ratio 2.5");
        run_case(32'h0001_0000, 0, 0, 0, 16'h0, 4'd0, 8'd0, 6, "R4 clamp 1.0");
        // R5: down spread ramp
        run_case(32'h000A_0000, 1, 0, 0, 16'h8000, 4'd2, 8'd0, 24, "R5 down spread");
        // R6: center spread
        run_case(32'h000A_0000, 1, 1, 0, 16'h8000, 4'd2, 8'd0, 24, "R6 center spread");
        run_case(32'h0007_3000, 1, 1, 0, 16'hC000, 4'd3, 8'd0, 40, "R6 center spread rate 3");
        // R7: disable forces plain ratio, ramp ignored
        run_case(32'h000A_0000, 1, 1, 1, 16'h8000, 4'd2, 8'd0, 16, "R7 spread disabled");
        run_case(32'h0005_4000, 0, 0, 0, 16'hFFFF, 4'd1, 8'd0, 12, "R7 spread off");
        // R8: phase delay, and phase ignored under spread
        run_case(32'h0004_0000, 0, 0, 0, 16'h0, 4'd0, 8'd5, 4, "R8 phase 5");
        run_case(32'h0004_0000, 1, 0, 0, 16'h4000, 4'd1, 8'd5, 8, "R8 phase with spread");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule